// File: doc/BRIEF.md
# Byte-Memory Two-Operand Processor Core

This block is a small multi-cycle processor. Every instruction is a fixed 16-bit word that the core takes from an instruction input port and runs through four states in order: fetch, decode, execute and writeback. The core has eight 16-bit general registers, a 16-bit instruction pointer and a status register that records faults. It can run four operations. Two are arithmetic: ADD and XOR, each between two registers. The other two move a single byte between a register and a 4096-byte data memory that sits inside the block.

Both operands of an instruction are register indexes. The first operand names the destination, or the data source when the instruction is a store. The second operand names the source register, or the register that holds the address for a load or a store.

The core checks each instruction for faults. When it finds one, it records a cause code, raises a sticky fault output and stops executing. Only a reset clears the fault. A debug port lets a test read any register without using an instruction.

Top module: `tls_core`

## Requirements
- R1: While reset is held, and on leaving reset, register k reads k × 0x10 (R0 = 0x0000 through R7 = 0x0070), the instruction pointer is 0 and no fault is shown.
- R2: An instruction word carries the opcode in bits 15:8, op0 in bits 7:4 and op1 in bits 3:0. The opcodes are LD = 0x00, ST = 0x01, ADD = 0x02 and XOR = 0x03. The core samples `instr_i` in the cycle where `fetch_o` is high. `retire_o` is high for exactly one cycle, three cycles after the fetch, and the next cycle is a fetch again.
- R3: ADD sets R[op0] = R[op0] + R[op1] whenever the unsigned 16-bit sum does not carry out.
- R4: XOR sets R[op0] = R[op0] ^ R[op1] and never faults.
- R5: ST writes bits 7:0 of R[op0] to the memory byte at the address held in R[op1], and leaves every register unchanged. LD writes that byte to R[op0], zero-extended to 16 bits.
- R6: The instruction pointer rises by 2 after each retired instruction and otherwise holds its value.
- R7: An opcode above 0x03 faults with cause 1. This check comes before the operand checks.
- R8: An op0 field above 7 faults with cause 2. An op1 field above 7 faults with cause 3. When both fields are above 7, the cause is 2.
- R9: An ADD whose sum carries out faults with cause 4 and leaves R[op0] unchanged. `fault_opa_o` and `fault_opb_o` then show the values of R[op0] and R[op1].
- R10: An LD or ST whose address is 4096 or higher faults with cause 5 and leaves the destination register unchanged.
- R11: Once a fault is raised, `fault_o` and `fault_cause_o` hold their values until reset. After that, no instruction retires, the instruction pointer is frozen and the registers do not change, whatever `instr_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 16 | Instruction word, sampled while `fetch_o` is high |
| fetch_o | output | 1 | The core is in its fetch state |
| instr_addr_o | output | 16 | Instruction pointer |
| retire_o | output | 1 | Writeback cycle of an instruction that completes without a fault |
| fault_o | output | 1 | Sticky fault indicator |
| fault_cause_o | output | 3 | Fault cause: 0 none, 1 opcode, 2 op0, 3 op1, 4 overflow, 5 address |
| fault_opa_o | output | 16 | Value of R[op0] captured on an ADD overflow |
| fault_opb_o | output | 16 | Value of R[op1] captured on an ADD overflow |
| dbg_idx_i | input | 3 | Register index for the debug read port |
| dbg_data_o | output | 16 | Combinational value of the register that `dbg_idx_i` selects |

## Verification
The assertions assume that reset is held low for at least two clock edges. This gives the instruction pointer a defined value before any `$past` comparison is made. They also assume that once the core has stopped on a fault, it stays stopped until reset is applied again, so the halt checks hold throughout the run.

The stimulus keeps to these limits in three ways. It asserts reset for three cycles before every test sequence. It changes `instr_i` only after the result of the previous instruction has been checked. It always loads from addresses that an earlier store has written, so that no value depends on memory contents that were never set.

// File: rtl/tls_pkg.sv
// Shared constants and types for the two-operand byte-memory core.
// Assumes a 16-bit instruction word with fixed field positions.
package tls_pkg;
    localparam int INSN_W = 16;

    localparam logic [7:0] OPC_LD  = 8'h00;
    localparam logic [7:0] OPC_ST  = 8'h01;
    localparam logic [7:0] OPC_ADD = 8'h02;
    localparam logic [7:0] OPC_XOR = 8'h03;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_OPCODE = 3'd1,
        CAUSE_OP0    = 3'd2,
        CAUSE_OP1    = 3'd3,
        CAUSE_OVF    = 3'd4,
        CAUSE_MEM    = 3'd5
    } cause_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB,
        ST_HALT
    } state_e;
endpackage

// File: rtl/tls_regfile.sv
// General register bank: one write port, two operand read ports and a
// debug read port, all reads combinational. On reset, register k takes
// the value k * RESET_STEP. Assumes that NUM_REGS is a power of two.
module tls_regfile #(
    parameter int DATA_W     = 16,
    parameter int NUM_REGS   = 8,
    parameter int RESET_STEP = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [$clog2(NUM_REGS)-1:0] widx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [$clog2(NUM_REGS)-1:0] ridx_a,
    output logic [DATA_W-1:0]           rdata_a,
    input  logic [$clog2(NUM_REGS)-1:0] ridx_b,
    output logic [DATA_W-1:0]           rdata_b,
    input  logic [$clog2(NUM_REGS)-1:0] ridx_d,
    output logic [DATA_W-1:0]           rdata_d
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    // Load the reset pattern or take one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                regs_q[k] <= DATA_W'(k * RESET_STEP);
            end
        end else if (we) begin
            regs_q[widx] <= wdata;
        end
    end

    assign rdata_a = regs_q[ridx_a];
    assign rdata_b = regs_q[ridx_b];
    assign rdata_d = regs_q[ridx_d];
endmodule

// File: rtl/tls_alu.sv
// Two-input arithmetic for ADD and XOR. The overflow output is the
// unsigned carry out of the sum; the caller decides when it matters.
module tls_alu #(
    parameter int DATA_W = 16
) (
    input  logic [7:0]        opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              carry
);
    import tls_pkg::*;

    logic [DATA_W:0] sum;

    // Form the wide sum and select the result by opcode.
    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        carry  = sum[DATA_W];
        result = (opc == OPC_XOR) ? (a ^ b) : sum[DATA_W-1:0];
    end
endmodule

// File: rtl/tls_dmem.sv
// Byte-wide data memory with a synchronous write and a combinational
// read. in_range reports whether the full address falls inside the
// array. Assumes that MEM_BYTES is a power of two.
module tls_dmem #(
    parameter int MEM_BYTES = 4096,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              in_range
);
    localparam int              MEM_AW = $clog2(MEM_BYTES);
    localparam logic [ADDR_W:0] LIMIT  = (ADDR_W+1)'(MEM_BYTES);

    logic [7:0] mem_q [MEM_BYTES];

    // Write one byte when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr[MEM_AW-1:0]] <= wdata;
        end
    end

    assign rdata    = mem_q[addr[MEM_AW-1:0]];
    assign in_range = ({1'b0, addr} < LIMIT);
endmodule

// File: rtl/tls_core.sv
// Multi-cycle core: FETCH -> DECODE -> EXECUTE -> WRITEBACK. Decode
// checks the opcode, then op0, then op1. Execute checks for an ADD
// carry and for a memory address out of range. Any fault latches a
// cause and parks the core in HALT until reset. Assumes that instr_i
// is stable in the cycle where fetch_o is high.
module tls_core #(
    parameter int DATA_W     = 16,
    parameter int NUM_REGS   = 8,
    parameter int RESET_STEP = 16,
    parameter int MEM_BYTES  = 4096,
    parameter int IP_STEP    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 instr_i,
    output logic                        fetch_o,
    output logic [DATA_W-1:0]           instr_addr_o,
    output logic                        retire_o,
    output logic                        fault_o,
    output logic [2:0]                  fault_cause_o,
    output logic [DATA_W-1:0]           fault_opa_o,
    output logic [DATA_W-1:0]           fault_opb_o,
    input  logic [$clog2(NUM_REGS)-1:0] dbg_idx_i,
    output logic [DATA_W-1:0]           dbg_data_o
);
    import tls_pkg::*;

    localparam int         IDX_W     = $clog2(NUM_REGS);
    localparam logic [3:0] REG_LIMIT = 4'(NUM_REGS);

    state_e                state_q;
    logic [INSN_W-1:0]     ir_q;
    logic [DATA_W-1:0]     ip_q, res_q, fa_q, fb_q;
    logic [3:0]            status_q;    // bit 0 halted, bits 3:1 cause

    logic [7:0]            opc;
    logic [3:0]            fld0, fld1;
    logic [DATA_W-1:0]     val_n, val_m, alu_res, ex_value;
    logic                  alu_carry, mem_ok, mem_we, rf_we;
    logic [7:0]            mem_rdata;
    cause_e                dec_cause, ex_cause;

    assign opc  = ir_q[15:8];
    assign fld0 = ir_q[7:4];
    assign fld1 = ir_q[3:0];

    tls_regfile #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RESET_STEP(RESET_STEP)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .widx(fld0[IDX_W-1:0]), .wdata(res_q),
        .ridx_a(fld0[IDX_W-1:0]), .rdata_a(val_n),
        .ridx_b(fld1[IDX_W-1:0]), .rdata_b(val_m),
        .ridx_d(dbg_idx_i), .rdata_d(dbg_data_o)
    );

    tls_alu #(.DATA_W(DATA_W)) u_alu (
        .opc(opc), .a(val_n), .b(val_m), .result(alu_res), .carry(alu_carry)
    );

    tls_dmem #(.MEM_BYTES(MEM_BYTES), .ADDR_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(val_m), .wdata(val_n[7:0]),
        .rdata(mem_rdata), .in_range(mem_ok)
    );

    // Decode-stage fault priority: opcode, then op0, then op1.
    always_comb begin
        dec_cause = CAUSE_NONE;
        if (opc > OPC_XOR)             dec_cause = CAUSE_OPCODE;
        else if (fld0 >= REG_LIMIT)    dec_cause = CAUSE_OP0;
        else if (fld1 >= REG_LIMIT)    dec_cause = CAUSE_OP1;
    end

    // Execute-stage result selection and fault detection.
    always_comb begin
        ex_cause = CAUSE_NONE;
        ex_value = alu_res;
        if (opc == OPC_ADD && alu_carry) ex_cause = CAUSE_OVF;
        if ((opc == OPC_LD || opc == OPC_ST) && !mem_ok) ex_cause = CAUSE_MEM;
        if (opc == OPC_LD) ex_value = {{(DATA_W-8){1'b0}}, mem_rdata};
    end

    assign mem_we = (state_q == ST_EXEC) && (opc == OPC_ST) && mem_ok;
    assign rf_we  = (state_q == ST_WB) && (opc != OPC_ST);

    // Sequencer: step through the states, latch faults, advance the IP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_FETCH;
            ir_q     <= '0;
            ip_q     <= '0;
            res_q    <= '0;
            fa_q     <= '0;
            fb_q     <= '0;
            status_q <= '0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    ir_q    <= instr_i;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (dec_cause != CAUSE_NONE) begin
                        status_q <= {dec_cause, 1'b1};
                        state_q  <= ST_HALT;
                    end else begin
                        state_q  <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (ex_cause != CAUSE_NONE) begin
                        status_q <= {ex_cause, 1'b1};
                        if (ex_cause == CAUSE_OVF) begin
                            fa_q <= val_n;
                            fb_q <= val_m;
                        end
                        state_q  <= ST_HALT;
                    end else begin
                        res_q    <= ex_value;
                        state_q  <= ST_WB;
                    end
                end
                ST_WB: begin
                    ip_q    <= ip_q + DATA_W'(IP_STEP);
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign fetch_o       = (state_q == ST_FETCH);
    assign retire_o      = (state_q == ST_WB);
    assign instr_addr_o  = ip_q;
    assign fault_o       = status_q[0];
    assign fault_cause_o = status_q[3:1];
    assign fault_opa_o   = fa_q;
    assign fault_opb_o   = fb_q;
endmodule

// File: rtl/tls_core_chk.sv
// Checker for the port-level sequencing and fault behaviour of tls_core.
// Assumes that reset is held low for at least two edges.
module tls_core_chk #(
    parameter int DATA_W  = 16,
    parameter int IP_STEP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_o,
    input logic              retire_o,
    input logic              fault_o,
    input logic [2:0]        fault_cause_o,
    input logic [DATA_W-1:0] instr_addr_o
);
    // R11
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o && $stable(fault_cause_o));

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !retire_o && !fetch_o);

    // R6
    ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> instr_addr_o == $past(instr_addr_o) + DATA_W'(IP_STEP));

    // R6
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_o |=> $stable(instr_addr_o));

    // R2
    retire_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_o |=> fetch_o && !retire_o);

    // R2
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !fetch_o && !retire_o);

    // R7
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_cause_o >= 3'd1) && (fault_cause_o <= 3'd5));
endmodule

bind tls_core tls_core_chk #(.DATA_W(DATA_W), .IP_STEP(IP_STEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_o(fetch_o), .retire_o(retire_o),
    .fault_o(fault_o), .fault_cause_o(fault_cause_o),
    .instr_addr_o(instr_addr_o)
);

// File: tb/tb_tls_core.sv
module tb_tls_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [2:0]  dbg_idx_i = 3'd0;
    logic        fetch_o, retire_o, fault_o;
    logic [2:0]  fault_cause_o;
    logic [15:0] instr_addr_o, fault_opa_o, fault_opb_o, dbg_data_o;

    always #4 clk = ~clk;   // 125 MHz

    tls_core dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .fetch_o(fetch_o),
        .instr_addr_o(instr_addr_o), .retire_o(retire_o), .fault_o(fault_o),
        .fault_cause_o(fault_cause_o), .fault_opa_o(fault_opa_o),
        .fault_opb_o(fault_opb_o), .dbg_idx_i(dbg_idx_i), .dbg_data_o(dbg_data_o)
    );

    typedef struct packed {
        logic        fault;
        logic [2:0]  cause;
        logic [2:0]  rd;
        logic [15:0] val;
        logic [15:0] ip;
        logic [15:0] fa;
        logic [15:0] fb;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    event  item_done;
    int    vectors = 0;
    int    miscompares = 0;

    logic [15:0] m_reg [8];
    logic [7:0]  m_mem [4096];
    logic [15:0] m_ip;

    task automatic check16(input string req, input string what,
                           input logic [15:0] act, input logic [15:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%h expected 0x%h", req, what, act, expv);
        end
    endtask

    task automatic read_reg(input logic [2:0] idx, output logic [15:0] val);
        dbg_idx_i = idx;
        #1;
        val = dbg_data_o;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Monitor: pop one expected item per retirement or new fault and compare.
    initial begin : monitor
        bit          prev_fault;
        bit          was_retire;
        exp_t        e;
        string       r;
        logic [15:0] v;
        prev_fault = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_fault = 1'b0;
            end else if (retire_o || (fault_o && !prev_fault)) begin
                was_retire = retire_o;
                if (was_retire) @(negedge clk);   // register write lands here
                if (exp_q.size() == 0) begin
                    vectors++;
                    miscompares++;
                    $display("FAIL R11 unexpected completion: actual event expected none");
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check16(r, "fault flag", {15'd0, fault_o}, {15'd0, e.fault});
                    check16(r, "cause", {13'd0, fault_cause_o}, {13'd0, e.cause});
                    check16(r, "ip", instr_addr_o, e.ip);
                    read_reg(e.rd, v);
                    check16(r, "op0 register", v, e.val);
                    if (e.cause == 3'd4) begin
                        check16(r, "overflow opa", fault_opa_o, e.fa);
                        check16(r, "overflow opb", fault_opb_o, e.fb);
                    end
                    ->item_done;
                end
                prev_fault = fault_o;
            end
        end
    end

    // Driver: model the instruction, queue the expectation, apply it.
    task automatic run(input logic [15:0] insn, input string req);
        exp_t        e;
        logic [7:0]  op;
        logic [3:0]  a, b;
        logic [16:0] sum;
        logic [15:0] addr;
        logic [2:0]  c;
        op = insn[15:8]; a = insn[7:4]; b = insn[3:0];
        c = 3'd0; e = '0;
        if (op > 8'h03)    c = 3'd1;
        else if (a > 4'd7) c = 3'd2;
        else if (b > 4'd7) c = 3'd3;
        else begin
            case (op)
                8'h00: begin
                    addr = m_reg[b[2:0]];
                    if (addr >= 16'd4096) c = 3'd5;
                    else m_reg[a[2:0]] = {8'h00, m_mem[addr[11:0]]};
                end
                8'h01: begin
                    addr = m_reg[b[2:0]];
                    if (addr >= 16'd4096) c = 3'd5;
                    else m_mem[addr[11:0]] = m_reg[a[2:0]][7:0];
                end
                8'h02: begin
                    sum = {1'b0, m_reg[a[2:0]]} + {1'b0, m_reg[b[2:0]]};
                    if (sum[16]) begin
                        c = 3'd4;
                        e.fa = m_reg[a[2:0]];
                        e.fb = m_reg[b[2:0]];
                    end else begin
                        m_reg[a[2:0]] = sum[15:0];
                    end
                end
                default: m_reg[a[2:0]] = m_reg[a[2:0]] ^ m_reg[b[2:0]];
            endcase
        end
        if (c == 3'd0) m_ip = m_ip + 16'd2;
        e.fault = (c != 3'd0);
        e.cause = c;
        e.rd    = a[2:0];
        e.val   = m_reg[a[2:0]];
        e.ip    = m_ip;
        exp_q.push_back(e);
        req_q.push_back(req);
        instr_i = insn;
        rst_n   = 1'b1;
        @(item_done);
    endtask

    // Hold reset, check the reset state (R1) and reload the model.
    task automatic reset_core();
        logic [15:0] v;
        rst_n   = 1'b0;
        instr_i = 16'h0000;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            m_reg[k] = 16'(k * 16);
            read_reg(3'(k), v);
            check16("R1", "reset register", v, m_reg[k]);
        end
        m_ip = 16'h0000;
        check16("R1", "reset ip", instr_addr_o, 16'h0000);
        check16("R1", "reset fault", {12'd0, fault_o, fault_cause_o}, 16'h0000);
    endtask

    // After a fault: apply a legal instruction and confirm nothing moves (R11).
    task automatic halt_probe(input logic [15:0] insn);
        logic [15:0] v;
        instr_i = insn;
        repeat (8) @(negedge clk);
        #1;
        check16("R11", "halted ip", instr_addr_o, m_ip);
        check16("R11", "fault held", {15'd0, fault_o}, 16'h0001);
        read_reg(insn[6:4], v);
        check16("R11", "halted register", v, m_reg[insn[6:4]]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R2 watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin : stimulus
        reset_core();
        run(16'h0245, "R3");   // ADD R4,R5 -> 0x0090 (field layout, R2)
        run(16'h0317, "R4");   // XOR R1,R7 -> 0x0060
        run(16'h0140, "R5");   // ST R4 -> [0x0000]
        run(16'h0020, "R5");   // LD R2 <- [0x0000] = 0x0090
        run(16'h0266, "R3");   // R6 0x60 -> 0xC0
        run(16'h0266, "R3");   // R6 -> 0x0180
        run(16'h0161, "R5");   // ST R6 -> [0x0060], truncated to 0x80
        run(16'h0031, "R5");   // LD R3 <- 0x0080, zero-extended
        run(16'h0333, "R4");   // XOR R3,R3 -> 0
        for (int i = 0; i < 5; i++) run(16'h0277, "R6");  // R7 -> 0x0E00
        run(16'h0157, "R5");   // ST R5 -> [0x0E00]
        run(16'h0007, "R5");   // LD R0 <- 0x0050
        run(16'h0277, "R3");   // R7 -> 0x1C00
        run(16'h0017, "R10");  // LD R1 <- [0x1C00]: address fault
        halt_probe(16'h0245);

        reset_core();
        run(16'h0412, "R7");   // illegal opcode
        halt_probe(16'h0311);

        reset_core();
        run(16'h05FF, "R7");   // opcode wins over bad operands
        reset_core();
        run(16'h029A, "R8");   // op0 wins over op1
        reset_core();
        run(16'h0219, "R8");   // op1 out of range
        reset_core();
        run(16'h0081, "R8");   // LD with op0 = 8

        reset_core();
        for (int i = 0; i < 9; i++) run(16'h0277, "R3");  // R7 -> 0xE000
        run(16'h0277, "R9");   // carry: fault, R7 kept, operands reported
        halt_probe(16'h0277);

        reset_core();
        for (int i = 0; i < 6; i++) run(16'h0277, "R6");  // R7 -> 0x1C00
        run(16'h0127, "R10");  // ST to 0x1C00: address fault

        rst_n = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end
endmodule